// File: doc/BRIEF.md
# Receive Character Matcher with Flow-Control and Address Roles

This block watches the stream of characters coming out of a serial receiver and compares each one, in the same cycle, against three programmable match characters. Each entry has a two-bit role. It can be switched off. It can only flag a hit. It can act as an in-band pause or resume character for the local transmitter. It can act as a station address on a nine-bit multidrop bus.

A hit sets a sticky per-entry status bit, which software clears by writing a one. A combined interrupt line is high while any status bit is set. Flow-control entries drive a pause request. The pause is applied to the transmitter only at a character boundary, which the transmitter reports through an idle input. Address entries drive a receive-enable flag that tells the downstream path whether the following data characters belong to this station.

Top module: `char_match_top`

## Requirements
- R1: After synchronous reset, match_status is 000, irq is 0, tx_pause is 0 and rx_enable is 0.
- R2: An entry with role 01 (interrupt only) whose 8-bit character equals rx_data[7:0] of a strobed character with rx_data[8]=0 sets its match_status bit (bit i for entry i) on the clock edge that samples the strobe, and irq is high while any status bit is set.
- R3: An entry with role 00 (disabled) never sets its status bit and has no other effect.
- R4: When several entries match the same character, all of their status bits are set together.
- R5: Status bits stay set until a one is written to the matching bit of status_clr. Clearing one bit leaves the others unchanged. A new hit in the same cycle as its clear leaves the bit set.
- R6: A hit on a role 10 (flow) entry whose entry_xoff bit is 1 sets an internal pause request on the sampling edge. tx_pause rises on the first later edge at which tx_idle is 1, and never rises while tx_idle is 0.
- R7: A hit on a role 10 entry whose entry_xoff bit is 0 clears the pause request, and tx_pause falls on the next edge after that.
- R8: A role 11 (address) entry compares only characters with rx_data[8]=1. An address character that hits any address entry sets rx_enable. An address character that hits none clears it. Characters with rx_data[8]=0 leave rx_enable unchanged.
- R9: Entries with roles 01 and 10 ignore characters with rx_data[8]=1. An address entry ignores characters with rx_data[8]=0.
- R10: If the same character hits both a pause entry and a resume entry, the pause wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 9 | Received character; bit 8 is the address flag |
| entry_char | input | 24 | Match characters, entry i in bits [8i+7:8i] |
| entry_mode | input | 6 | Roles, entry i in bits [2i+1:2i]: 00 off, 01 interrupt, 10 flow, 11 address |
| entry_xoff | input | 3 | For flow entries: 1 marks pause, 0 marks resume |
| status_clr | input | 3 | Write-one-to-clear for match_status |
| tx_idle | input | 1 | Transmitter is between characters |
| match_status | output | 3 | Sticky per-entry hit bits |
| irq | output | 1 | High while any status bit is set |
| tx_pause | output | 1 | Holds off the transmitter |
| rx_enable | output | 1 | Data characters after a matching address are accepted |

## Verification
A wrong compare or role decode shows up as a wrong match_status bit one edge after the strobe. The same goes for a dropped hit or a hit where the address flag should block it. A sticky bit that leaks or clears the wrong bit is visible on the first edge after a clear write. A wrong pause request shows on tx_pause within two edges, or stays hidden while tx_idle is held low. A wrong receive-enable state is seen directly on rx_enable one edge after the next address character.

// File: rtl/cm_pkg.sv
package cm_pkg;
    localparam int DATA_W  = 8;
    localparam int CHAR_W  = DATA_W + 1;
    localparam int NUM_ENT = 3;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        ROLE_OFF  = 2'b00,
        ROLE_IRQ  = 2'b01,
        ROLE_FLOW = 2'b10,
        ROLE_ADDR = 2'b11
    } role_e;

    typedef struct packed {
        logic hit;
        logic pause;
        logic resume;
        logic addr;
    } ent_hit_t;

    function automatic logic entry_fires(role_e role, logic [CHAR_W-1:0] ch,
                                         logic [DATA_W-1:0] pattern);
        logic same;
        same = (ch[DATA_W-1:0] == pattern);
        case (role)
            ROLE_OFF:  entry_fires = 1'b0;
            ROLE_ADDR: entry_fires = same && ch[DATA_W];
            default:   entry_fires = same && !ch[DATA_W];
        endcase
    endfunction
endpackage

// File: rtl/cm_entry.sv
module cm_entry
    import cm_pkg::*;
(
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [DATA_W-1:0] pattern,
    input  role_e             role,
    input  logic              is_pause,
    output ent_hit_t          result
);
    logic fire;

    always_comb begin
        fire          = rx_valid && entry_fires(role, rx_data, pattern);
        result.hit    = fire;
        result.pause  = fire && (role == ROLE_FLOW) && is_pause;
        result.resume = fire && (role == ROLE_FLOW) && !is_pause;
        result.addr   = fire && (role == ROLE_ADDR);
    end
endmodule

// File: rtl/cm_flow.sv
module cm_flow (
    input  logic clk,
    input  logic rst,
    input  logic pause_hit,
    input  logic resume_hit,
    input  logic tx_idle,
    output logic tx_pause
);
    logic pause_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_req <= 1'b0;
            tx_pause  <= 1'b0;
        end else begin
            if (pause_hit)
                pause_req <= 1'b1;
            else if (resume_hit)
                pause_req <= 1'b0;
            tx_pause <= pause_req && (tx_pause || tx_idle);
        end
    end
endmodule

// File: rtl/cm_addr.sv
module cm_addr (
    input  logic clk,
    input  logic rst,
    input  logic addr_char,
    input  logic addr_hit,
    output logic rx_enable
);
    always_ff @(posedge clk) begin
        if (rst)
            rx_enable <= 1'b0;
        else if (addr_char)
            rx_enable <= addr_hit;
    end
endmodule

// File: rtl/cm_status.sv
module cm_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (status & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/char_match_top.sv
module char_match_top
    import cm_pkg::*;
#(
    parameter int N_ENT = NUM_ENT,
    parameter int DW    = DATA_W,
    localparam int CW   = DW + 1,
    localparam int MW   = MODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [CW-1:0]      rx_data,
    input  logic [N_ENT*DW-1:0] entry_char,
    input  logic [N_ENT*MW-1:0] entry_mode,
    input  logic [N_ENT-1:0]   entry_xoff,
    input  logic [N_ENT-1:0]   status_clr,
    input  logic               tx_idle,
    output logic [N_ENT-1:0]   match_status,
    output logic               irq,
    output logic               tx_pause,
    output logic               rx_enable
);
    ent_hit_t [N_ENT-1:0] hits;
    logic [N_ENT-1:0] hit_vec, pause_vec, resume_vec, addr_vec;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        cm_entry u_ent (
            .rx_valid (rx_valid),
            .rx_data  (rx_data),
            .pattern  (entry_char[i*DW +: DW]),
            .role     (role_e'(entry_mode[i*MW +: MW])),
            .is_pause (entry_xoff[i]),
            .result   (hits[i])
        );
        assign hit_vec[i]    = hits[i].hit;
        assign pause_vec[i]  = hits[i].pause;
        assign resume_vec[i] = hits[i].resume;
        assign addr_vec[i]   = hits[i].addr;
    end

    cm_status #(.N(N_ENT)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_bits (hit_vec),
        .clr_bits (status_clr),
        .status   (match_status)
    );

    cm_flow u_flow (
        .clk        (clk),
        .rst        (rst),
        .pause_hit  (|pause_vec),
        .resume_hit (|resume_vec),
        .tx_idle    (tx_idle),
        .tx_pause   (tx_pause)
    );

    cm_addr u_addr (
        .clk       (clk),
        .rst       (rst),
        .addr_char (rx_valid && rx_data[DW]),
        .addr_hit  (|addr_vec),
        .rx_enable (rx_enable)
    );

    assign irq = |match_status;
endmodule

// File: rtl/cm_checker.sv
module cm_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       tx_idle,
    input logic [5:0] entry_mode,
    input logic [2:0] status_clr,
    input logic [2:0] match_status,
    input logic       tx_pause,
    input logic       rx_enable
);
    logic [2:0] enabled;
    always_comb begin
        for (int i = 0; i < 3; i++)
            enabled[i] = (entry_mode[2*i +: 2] != 2'b00);
    end

    // R5: a status bit only falls after a clear write to it
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ((($past(match_status) & ~match_status) & ~$past(status_clr)) == 3'b000));

    // R3: a disabled entry never raises its status bit
    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (((match_status & ~$past(match_status)) & ~$past(enabled)) == 3'b000));

    // R2: a status bit rises only after a character strobe
    assert_set_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        ((match_status & ~$past(match_status)) != 3'b000) |-> $past(rx_valid));

    // R6: the pause reaches the transmitter only at a character boundary
    assert_pause_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_pause) |-> $past(tx_idle));

    // R8: receive enable moves only on a character strobe
    assert_enable_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_valid) |-> $stable(rx_enable));
endmodule

bind char_match_top cm_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .tx_idle      (tx_idle),
    .entry_mode   (entry_mode),
    .status_clr   (status_clr),
    .match_status (match_status),
    .tx_pause     (tx_pause),
    .rx_enable    (rx_enable)
);

// File: tb/tb_char_match_top.sv
module tb_char_match_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [8:0] rx_data = '0;
    logic [7:0] char_q [3];
    logic [1:0] mode_q [3];
    logic [2:0] xoff_q = 3'b000;
    logic [2:0] status_clr = '0;
    logic tx_idle = 1'b0;
    logic [23:0] entry_char;
    logic [5:0]  entry_mode;
    logic [2:0]  match_status;
    logic irq, tx_pause, rx_enable;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic       en;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    logic [2:0] st_m = '0;
    logic       en_m = 1'b0;
    logic       pause_m = 1'b0;

    assign entry_char = {char_q[2], char_q[1], char_q[0]};
    assign entry_mode = {mode_q[2], mode_q[1], mode_q[0]};

    always #5 clk = ~clk;

    char_match_top dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .entry_char(entry_char), .entry_mode(entry_mode), .entry_xoff(xoff_q),
        .status_clr(status_clr), .tx_idle(tx_idle), .match_status(match_status),
        .irq(irq), .tx_pause(tx_pause), .rx_enable(rx_enable)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [2:0] model_hits(logic [8:0] ch);
        logic [2:0] h;
        for (int i = 0; i < 3; i++)
            h[i] = (mode_q[i] != 2'b00) && (ch[7:0] == char_q[i]) &&
                   (ch[8] == (mode_q[i] == 2'b11));
        return h;
    endfunction

    // driver: one strobe, model update, expected item pushed
    task automatic send(logic [8:0] ch, logic [2:0] clr, string tag);
        logic [2:0] h;
        logic pz, rs;
        exp_t e;
        h = model_hits(ch);
        pz = 1'b0;
        rs = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (h[i] && mode_q[i] == 2'b10 && xoff_q[i]) pz = 1'b1;
            if (h[i] && mode_q[i] == 2'b10 && !xoff_q[i]) rs = 1'b1;
        end
        st_m = (st_m & ~clr) | h;
        if (pz) pause_m = 1'b1;
        else if (rs) pause_m = 1'b0;
        if (ch[8]) en_m = |(h & {mode_q[2] == 2'b11, mode_q[1] == 2'b11, mode_q[0] == 2'b11});
        e.st = st_m;
        e.en = en_m;
        e.tag = tag;
        sb_q.push_back(e);
        rx_data = ch;
        rx_valid = 1'b1;
        status_clr = clr;
        @(negedge clk);
        rx_valid = 1'b0;
        status_clr = '0;
    endtask

    task automatic clear(logic [2:0] clr, string tag);
        st_m = st_m & ~clr;
        status_clr = clr;
        @(negedge clk);
        status_clr = '0;
        check({tag, " status after clear"}, 32'(match_status), 32'(st_m));
    endtask

    // monitor: pops one expected item per sampled strobe
    always @(posedge clk) begin
        if (!rst && rx_valid) begin
            #2;
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " match_status"}, 32'(match_status), 32'(e.st));
                check({e.tag, " rx_enable"}, 32'(rx_enable), 32'(e.en));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        char_q[0] = 8'h13; mode_q[0] = 2'b10;   // pause entry
        char_q[1] = 8'h11; mode_q[1] = 2'b10;   // resume entry
        char_q[2] = 8'h41; mode_q[2] = 2'b01;   // interrupt only
        xoff_q = 3'b001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", 32'(match_status), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 tx_pause", 32'(tx_pause), 0);
        check("R1 rx_enable", 32'(rx_enable), 0);

        send(9'h041, 3'b000, "R2 irq-only hit");
        check("R2 irq", 32'(irq), 1);
        clear(3'b100, "R5");
        check("R5 irq low after clear", 32'(irq), 0);

        send(9'h141, 3'b000, "R9 address flag ignored by irq entry");

        mode_q[1] = 2'b00;
        send(9'h011, 3'b000, "R3 disabled entry");
        mode_q[1] = 2'b10;

        char_q[2] = 8'h13;
        send(9'h013, 3'b000, "R4 two entries hit");
        repeat (3) @(negedge clk);
        check("R6 pause held while tx busy", 32'(tx_pause), 0);
        tx_idle = 1'b1;
        @(negedge clk);
        check("R6 pause at boundary", 32'(tx_pause), 1);
        clear(3'b001, "R5 single bit");

        send(9'h011, 3'b000, "R7 resume hit");
        @(negedge clk);
        check("R7 pause dropped", 32'(tx_pause), 0);

        char_q[1] = 8'h13;
        send(9'h013, 3'b000, "R10 pause and resume together");
        @(negedge clk);
        check("R10 pause wins", 32'(tx_pause), 1);
        char_q[1] = 8'h11;
        send(9'h011, 3'b000, "R7 resume again");
        @(negedge clk);
        check("R7 pause dropped again", 32'(tx_pause), 0);

        clear(3'b111, "R5 all");
        send(9'h013, 3'b001, "R5 set wins over clear");
        send(9'h011, 3'b000, "R7 resume cleanup");

        clear(3'b111, "R5 all again");
        char_q[2] = 8'h05; mode_q[2] = 2'b11;
        send(9'h105, 3'b000, "R8 address match");
        send(9'h005, 3'b000, "R9 data char same value");
        send(9'h022, 3'b000, "R8 data char keeps enable");
        send(9'h107, 3'b000, "R8 foreign address");
        send(9'h005, 3'b000, "R8 data after foreign address");
        send(9'h105, 3'b000, "R8 address match again");
        @(negedge clk);
        check("R1 scoreboard drained", 32'(sb_q.size()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule